// File: doc/BRIEF.md
# Page-Table Refill Walker

The walker sits next to a translation buffer and services its misses without software help. When a fetch-side or data-side lookup misses, the walker takes the virtual address, forms the address of the matching 32-bit page-table entry from a base register, and asks the data translation buffer, through a lookup-only port, where that entry lives in physical memory. If that lookup succeeds, it reads the entry over a simple request/valid memory port. It then writes the entry into one of four refill ways, picked by a rotating counter, and records the faulting virtual address.

When the entry address cannot itself be translated, or the memory read returns an error, the walk ends with the original miss cause. The lookup for the entry address never starts a second walk. A probe request runs the same walk but writes nothing: the fetched entry and its ring come back on the response port only. One miss is handled at a time, and a new miss is accepted only while the walker is idle.

Top module: `pte_refill_walker`

## Requirements
- R1: The entry address presented on `lk_vaddr` equals (`pte_base` OR (`miss_vaddr` >> 10)) with bits 1:0 cleared, and `lk_req` is high for exactly the one cycle after a miss is accepted.
- R2: After a lookup hit, `mem_rd_req` is raised with `mem_rd_addr` equal to the returned physical address, and both hold steady until `mem_rd_valid` is seen.
- R3: A lookup miss on the entry address ends the walk with no memory read and no table write. `done` and `fault` are then high together, with `fault_cause` = 16 for a fetch miss (`miss_is_ifetch`=1) or 24 for a data miss.
- R4: A memory read error (`mem_rd_err` with `mem_rd_valid`) ends the walk the same way as R3: original miss cause and no table write.
- R5: A successful non-probe walk produces one `tlb_wr_en` pulse that carries the faulting virtual address, the fetched entry and the fetch/data flag. `done` follows in the next cycle with `fault` low.
- R6: The refill way is the refill counter pre-incremented, low two bits. The counter is 0 after reset, so successive refills go to ways 1, 2, 3, 0, 1.
- R7: `excvaddr` is 0 after reset and changes only on a successful non-probe refill, when it takes the faulting virtual address.
- R8: The ring of a fetched mapping is bits 5:4 of the entry, shown on `tlb_wr_ring` and `rsp_ring`.
- R9: A probe walk writes no table entry, leaves `excvaddr` and the refill counter unchanged, and returns the entry on `rsp_pte` when `done` is high.
- R10: `miss_ready` is high only in idle. A `miss_valid` raised while a walk is in progress is ignored, and the walker is idle again the cycle after `done`.
- R11: After reset the walker is idle, with `lk_req`, `mem_rd_req`, `tlb_wr_en` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pte_base | input | 32 | Page-table base register value |
| miss_valid | input | 1 | Miss request present |
| miss_vaddr | input | 32 | Missing virtual address |
| miss_is_ifetch | input | 1 | 1 = fetch-side miss, 0 = data-side miss |
| miss_probe | input | 1 | Probe: translate without writing the buffer |
| miss_ready | output | 1 | Walker idle, miss accepted |
| lk_req | output | 1 | Data-buffer lookup of the entry address, lookup only |
| lk_vaddr | output | 32 | Entry virtual address |
| lk_hit | input | 1 | Lookup hit |
| lk_paddr | input | 32 | Entry physical address on hit |
| mem_rd_req | output | 1 | Memory read request, held until valid |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_valid | input | 1 | Read response present |
| mem_rd_data | input | 32 | Read data (page-table entry) |
| mem_rd_err | input | 1 | Read response is an error |
| tlb_wr_en | output | 1 | Buffer write pulse |
| tlb_wr_way | output | 2 | Refill way |
| tlb_wr_vaddr | output | 32 | Virtual address of the refilled mapping |
| tlb_wr_pte | output | 32 | Fetched entry |
| tlb_wr_ring | output | 2 | Ring of the refilled mapping |
| tlb_wr_ifetch | output | 1 | Write goes to the fetch-side buffer |
| excvaddr | output | 32 | Faulting address of the last refill |
| done | output | 1 | Walk finished, one cycle |
| fault | output | 1 | Walk failed (valid with done) |
| fault_cause | output | 8 | Original miss cause on failure |
| rsp_pte | output | 32 | Fetched entry (valid with done, no fault) |
| rsp_ring | output | 2 | Ring of the fetched entry |

## Verification
Walks run with zero and several cycles of memory latency, for both fetch and data misses. This separates a walker that waits on `mem_rd_valid` from one that assumes a fixed delay, and shows that the fetch/data flag is carried through to the write. Enough successful refills are run to wrap the way counter. A probe is placed between two of them, so a probe that moves the counter or `excvaddr` shows up as a skipped way. Failed lookups and read errors are run for each miss kind, to tell the two fault causes apart and to confirm that no write escapes. A miss raised while a walk is in progress must leave that walk's address and results untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_XLATE = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } walk_state_e;

    localparam int IMISS_CAUSE_DEF = 16;
    localparam int DMISS_CAUSE_DEF = 24;
endpackage

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr #(
    parameter int AW        = 32,
    parameter int PTE_SHIFT = 10,
    parameter int PTE_ALIGN = 2
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] vaddr,
    output logic [AW-1:0] pte_addr
);
    localparam logic [AW-1:0] LOW_BITS   = AW'((1 << PTE_ALIGN) - 1);
    localparam logic [AW-1:0] ALIGN_MASK = ~LOW_BITS;

    logic [AW-1:0] shifted;

    always_comb begin
        shifted  = vaddr >> PTE_SHIFT;
        pte_addr = (base | shifted) & ALIGN_MASK;
    end
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
    parameter int CNT_W = 8,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WAY_W-1:0] next_way
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc  = cnt_q + 1'b1;
        next_way = cnt_inc[WAY_W-1:0];
        cnt_d    = advance ? cnt_inc : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pte_refill_walker.sv
module pte_refill_walker #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int PTE_SHIFT   = 10,
    parameter int PTE_ALIGN   = 2,
    parameter int RING_LSB    = 4,
    parameter int RING_W      = 2,
    parameter int WAY_W       = 2,
    parameter int CNT_W       = 8,
    parameter int CAUSE_W     = 8,
    parameter int IMISS_CAUSE = ptw_pkg::IMISS_CAUSE_DEF,
    parameter int DMISS_CAUSE = ptw_pkg::DMISS_CAUSE_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      pte_base,
    input  logic               miss_valid,
    input  logic [AW-1:0]      miss_vaddr,
    input  logic               miss_is_ifetch,
    input  logic               miss_probe,
    output logic               miss_ready,
    output logic               lk_req,
    output logic [AW-1:0]      lk_vaddr,
    input  logic               lk_hit,
    input  logic [AW-1:0]      lk_paddr,
    output logic               mem_rd_req,
    output logic [AW-1:0]      mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DW-1:0]      mem_rd_data,
    input  logic               mem_rd_err,
    output logic               tlb_wr_en,
    output logic [WAY_W-1:0]   tlb_wr_way,
    output logic [AW-1:0]      tlb_wr_vaddr,
    output logic [DW-1:0]      tlb_wr_pte,
    output logic [RING_W-1:0]  tlb_wr_ring,
    output logic               tlb_wr_ifetch,
    output logic [AW-1:0]      excvaddr,
    output logic               done,
    output logic               fault,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic [DW-1:0]      rsp_pte,
    output logic [RING_W-1:0]  rsp_ring
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e   state;
        logic [AW-1:0] vaddr;
        logic          is_if;
        logic          probe;
        logic [AW-1:0] pte_addr;
        logic [AW-1:0] pa;
        logic [DW-1:0] pte;
        logic          fail;
        logic [AW-1:0] excv;
    } walk_regs_t;

    walk_regs_t d, q;
    logic [AW-1:0] pte_addr_calc;
    logic          way_advance;

    ptw_pte_addr #(
        .AW        (AW),
        .PTE_SHIFT (PTE_SHIFT),
        .PTE_ALIGN (PTE_ALIGN)
    ) addr_i (
        .base     (pte_base),
        .vaddr    (miss_vaddr),
        .pte_addr (pte_addr_calc)
    );

    ptw_way_ctr #(
        .CNT_W (CNT_W),
        .WAY_W (WAY_W)
    ) way_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (way_advance),
        .next_way (tlb_wr_way)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (miss_valid) begin
                    d.vaddr    = miss_vaddr;
                    d.is_if    = miss_is_ifetch;
                    d.probe    = miss_probe;
                    d.pte_addr = pte_addr_calc;
                    d.fail     = 1'b0;
                    d.state    = ST_XLATE;
                end
            end
            ST_XLATE: begin
                if (lk_hit) begin
                    d.pa    = lk_paddr;
                    d.state = ST_READ;
                end else begin
                    d.fail  = 1'b1;
                    d.state = ST_DONE;
                end
            end
            ST_READ: begin
                if (mem_rd_valid) begin
                    if (mem_rd_err) begin
                        d.fail  = 1'b1;
                        d.state = ST_DONE;
                    end else begin
                        d.pte   = mem_rd_data;
                        d.state = q.probe ? ST_DONE : ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                d.excv  = q.vaddr;
                d.state = ST_DONE;
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        miss_ready    = (q.state == ST_IDLE);
        lk_req        = (q.state == ST_XLATE);
        lk_vaddr      = q.pte_addr;
        mem_rd_req    = (q.state == ST_READ);
        mem_rd_addr   = q.pa;
        tlb_wr_en     = (q.state == ST_WRITE);
        way_advance   = tlb_wr_en;
        tlb_wr_vaddr  = q.vaddr;
        tlb_wr_pte    = q.pte;
        tlb_wr_ring   = q.pte[RING_LSB +: RING_W];
        tlb_wr_ifetch = q.is_if;
        excvaddr      = q.excv;
        done          = (q.state == ST_DONE);
        fault         = done && q.fail;
        fault_cause   = '0;
        if (fault) begin
            fault_cause = q.is_if ? CAUSE_W'(IMISS_CAUSE) : CAUSE_W'(DMISS_CAUSE);
        end
        rsp_pte       = q.pte;
        rsp_ring      = q.pte[RING_LSB +: RING_W];
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int AW          = 32,
    parameter int WAY_W       = 2,
    parameter int CAUSE_W     = 8,
    parameter int IMISS_CAUSE = 16,
    parameter int DMISS_CAUSE = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_valid,
    input logic               miss_is_ifetch,
    input logic               miss_ready,
    input logic               lk_req,
    input logic               mem_rd_req,
    input logic [AW-1:0]      mem_rd_addr,
    input logic               mem_rd_valid,
    input logic               tlb_wr_en,
    input logic [WAY_W-1:0]   tlb_wr_way,
    input logic [AW-1:0]      excvaddr,
    input logic               done,
    input logic               fault,
    input logic [CAUSE_W-1:0] fault_cause
);
    logic             cap_if;
    logic [WAY_W-1:0] last_way;
    logic [WAY_W-1:0] exp_way;

    assign exp_way = last_way + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_if   <= 1'b0;
            last_way <= '0;
        end else begin
            if (miss_valid && miss_ready) cap_if <= miss_is_ifetch;
            if (tlb_wr_en) last_way <= tlb_wr_way;
        end
    end

    // R6
    way_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |-> tlb_wr_way == exp_way);

    // R3
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> fault_cause == (cap_if ? CAUSE_W'(IMISS_CAUSE) : CAUSE_W'(DMISS_CAUSE)));

    // R5
    write_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |=> (done && !fault));

    // R7
    excv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tlb_wr_en |=> $stable(excvaddr));

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R10
    idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> miss_ready);

    // R11
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({miss_ready, lk_req, mem_rd_req, tlb_wr_en, done}));
endmodule

bind pte_refill_walker ptw_walker_chk #(
    .AW          (AW),
    .WAY_W       (WAY_W),
    .CAUSE_W     (CAUSE_W),
    .IMISS_CAUSE (IMISS_CAUSE),
    .DMISS_CAUSE (DMISS_CAUSE)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_is_ifetch (miss_is_ifetch),
    .miss_ready     (miss_ready),
    .lk_req         (lk_req),
    .mem_rd_req     (mem_rd_req),
    .mem_rd_addr    (mem_rd_addr),
    .mem_rd_valid   (mem_rd_valid),
    .tlb_wr_en      (tlb_wr_en),
    .tlb_wr_way     (tlb_wr_way),
    .excvaddr       (excvaddr),
    .done           (done),
    .fault          (fault),
    .fault_cause    (fault_cause)
);

// File: tb/pte_refill_walker_tb_top.sv
`timescale 1ns/1ps
module pte_refill_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pte_base = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_vaddr = '0;
    logic        miss_is_ifetch = 1'b0;
    logic        miss_probe = 1'b0;
    logic        miss_ready;
    logic        lk_req;
    logic [31:0] lk_vaddr;
    logic        lk_hit = 1'b0;
    logic [31:0] lk_paddr = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_rd_err = 1'b0;
    logic        tlb_wr_en;
    logic [1:0]  tlb_wr_way;
    logic [31:0] tlb_wr_vaddr;
    logic [31:0] tlb_wr_pte;
    logic [1:0]  tlb_wr_ring;
    logic        tlb_wr_ifetch;
    logic [31:0] excvaddr;
    logic        done;
    logic        fault;
    logic [7:0]  fault_cause;
    logic [31:0] rsp_pte;
    logic [1:0]  rsp_ring;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int refills = 0;
    logic [31:0] exp_excv = '0;

    always #2 clk = ~clk;

    pte_refill_walker dut_i (
        .clk(clk), .rst_n(rst_n), .pte_base(pte_base),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
        .miss_is_ifetch(miss_is_ifetch), .miss_probe(miss_probe),
        .miss_ready(miss_ready), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_way(tlb_wr_way),
        .tlb_wr_vaddr(tlb_wr_vaddr), .tlb_wr_pte(tlb_wr_pte),
        .tlb_wr_ring(tlb_wr_ring), .tlb_wr_ifetch(tlb_wr_ifetch),
        .excvaddr(excvaddr), .done(done), .fault(fault),
        .fault_cause(fault_cause), .rsp_pte(rsp_pte), .rsp_ring(rsp_ring)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", "cycle limit", cyc, 20000);
            finish_run();
        end
    end

    // One complete walk; every cycle's outputs compared against the behavioural model.
    task automatic walk(input logic [31:0] va, input bit ifc, input bit prb,
                        input bit hit, input logic [31:0] pa, input int lat,
                        input bit err, input logic [31:0] pte, input bit noise);
        logic [31:0] exp_addr;
        bit ok_walk;
        int way_exp;
        exp_addr = (pte_base | (va >> 10)) & 32'hFFFF_FFFC;
        ok_walk  = hit && !err;
        @(negedge clk);
        chk(miss_ready == 1'b1, "R10", "ready in idle", miss_ready, 1);
        miss_valid = 1'b1; miss_vaddr = va; miss_is_ifetch = ifc; miss_probe = prb;
        @(posedge clk); @(negedge clk);
        miss_valid = noise;
        miss_vaddr = noise ? 32'h5555_0000 : va;
        miss_is_ifetch = noise ? !ifc : ifc;
        miss_probe = 1'b0;
        chk(lk_req == 1'b1, "R1", "lookup request", lk_req, 1);
        chk(lk_vaddr == exp_addr, "R1", "entry address", lk_vaddr, exp_addr);
        chk(miss_ready == 1'b0, "R10", "busy not ready", miss_ready, 0);
        lk_hit = hit; lk_paddr = pa;
        @(posedge clk); @(negedge clk);
        lk_hit = 1'b0; miss_valid = 1'b0;
        chk(lk_req == 1'b0, "R1", "lookup one cycle", lk_req, 0);
        if (hit) begin
            for (int i = 0; i < lat; i++) begin
                chk(mem_rd_req == 1'b1 && mem_rd_addr == pa, "R2", "read held", mem_rd_addr, pa);
                @(posedge clk); @(negedge clk);
            end
            chk(mem_rd_req == 1'b1 && mem_rd_addr == pa, "R2", "read addr", mem_rd_addr, pa);
            mem_rd_valid = 1'b1; mem_rd_data = pte; mem_rd_err = err;
            @(posedge clk); @(negedge clk);
            mem_rd_valid = 1'b0; mem_rd_err = 1'b0;
        end else begin
            chk(mem_rd_req == 1'b0, "R3", "no read after lookup miss", mem_rd_req, 0);
        end
        if (ok_walk && !prb) begin
            way_exp = (refills + 1) % 4;
            chk(tlb_wr_en == 1'b1, "R5", "write pulse", tlb_wr_en, 1);
            chk(tlb_wr_way == 2'(way_exp), "R6", "refill way", tlb_wr_way, way_exp);
            chk(tlb_wr_vaddr == va && tlb_wr_pte == pte, "R5", "write payload", tlb_wr_pte, pte);
            chk(tlb_wr_ifetch == ifc, "R5", "write side", tlb_wr_ifetch, ifc);
            chk(tlb_wr_ring == pte[5:4], "R8", "write ring", tlb_wr_ring, pte[5:4]);
            chk(done == 1'b0, "R5", "done after write", done, 0);
            refills++;
            exp_excv = va;
            @(posedge clk); @(negedge clk);
        end else begin
            chk(tlb_wr_en == 1'b0, prb ? "R9" : (hit ? "R4" : "R3"), "no write", tlb_wr_en, 0);
        end
        chk(done == 1'b1, "R5", "done pulse", done, 1);
        chk(fault == !ok_walk, hit ? "R4" : "R3", "fault flag", fault, !ok_walk);
        if (!ok_walk) begin
            chk(fault_cause == (ifc ? 8'd16 : 8'd24), hit ? "R4" : "R3", "cause",
                fault_cause, ifc ? 16 : 24);
        end else begin
            chk(rsp_pte == pte, "R9", "response entry", rsp_pte, pte);
            chk(rsp_ring == pte[5:4], "R8", "response ring", rsp_ring, pte[5:4]);
        end
        chk(tlb_wr_en == 1'b0, "R5", "single write", tlb_wr_en, 0);
        @(posedge clk); @(negedge clk);
        chk(miss_ready == 1'b1 && done == 1'b0, "R10", "idle after done", miss_ready, 1);
        chk(excvaddr == exp_excv, "R7", "fault address", excvaddr, exp_excv);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk(miss_ready == 1'b1, "R11", "reset ready", miss_ready, 1);
        chk({lk_req, mem_rd_req, tlb_wr_en, done} == 4'b0, "R11", "reset quiet",
            {lk_req, mem_rd_req, tlb_wr_en, done}, 0);
        chk(excvaddr == 32'h0, "R11", "reset excvaddr", excvaddr, 0);

        pte_base = 32'hC000_0000;
        // data refill, immediate read: way 1
        walk(32'h1234_5678, 1'b0, 1'b0, 1'b1, 32'h0040_0010, 0, 1'b0, 32'hABCD_E017, 1'b0);
        // fetch refill, latency 3: way 2, ring 2
        walk(32'h8765_4321, 1'b1, 1'b0, 1'b1, 32'h0040_2000, 3, 1'b0, 32'h1111_1023, 1'b0);
        // probe: no write, counter and excvaddr untouched
        walk(32'h0BAD_F00D, 1'b0, 1'b1, 1'b1, 32'h0050_0000, 2, 1'b0, 32'h2222_2035, 1'b0);
        // lookup misses, both sides
        walk(32'h4000_1000, 1'b1, 1'b0, 1'b0, 32'h0, 0, 1'b0, 32'h0, 1'b0);
        walk(32'h4000_2000, 1'b0, 1'b0, 1'b0, 32'h0, 0, 1'b0, 32'h0, 1'b0);
        // read errors, both sides
        walk(32'h5000_3000, 1'b0, 1'b0, 1'b1, 32'h0060_0000, 1, 1'b1, 32'hFFFF_FFFF, 1'b0);
        walk(32'h5000_4000, 1'b1, 1'b0, 1'b1, 32'h0060_0004, 0, 1'b1, 32'hFFFF_FFFF, 1'b0);
        // refill with a competing miss during the walk: way 3
        pte_base = 32'hFFC0_0003;
        walk(32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1, 32'h0070_0000, 1, 1'b0, 32'h3333_3007, 1'b1);
        // wrap to way 0 then way 1
        walk(32'h0000_0400, 1'b1, 1'b0, 1'b1, 32'h0070_0100, 4, 1'b0, 32'h4444_4011, 1'b0);
        walk(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0070_0200, 0, 1'b0, 32'h5555_5030, 1'b0);
        finish_run();
    end
endmodule